// File: doc/BRIEF.md
# Look-Ahead Pipelined First-Order Recursive Filter

This block is a single-pole recursive filter for a stream of signed fixed-point samples. Its nominal behaviour is the one-step recursion y(n) = a·y(n−1) + b·x(n). A direct build of that recursion puts a multiplier and an adder inside a one-register loop, and that loop sets the clock rate. Here the recursion is unrolled M steps ahead: y(n) = a^M·y(n−M) + Σ_{i=0}^{M−1} a^i·b·x(n−i). The loop then holds M registers, and the loop multiplier gets its own pipeline register.

The gain a, the input scale b and the look-ahead depth M are parameters. The loop gain a^M and the feed-forward taps a^i·b are worked out at elaboration, with the same fixed-point rounding used on the datapath. The sum over past inputs is a non-recursive M-tap section with no feedback of its own. A sample is accepted in any cycle where its valid is high, and the whole state advances only on accepted samples. Gaps in the stream therefore do not change the computed sequence.

Top module: `la_iir1`

## Requirements
- R1: While reset is low, and in the first cycle after it, `y_vld` is 0 and `y_out` is 0.
- R2: Each cycle with `x_vld` high makes `y_vld` high in exactly the next cycle. A cycle with `x_vld` low makes `y_vld` low in the next cycle.
- R3: For the k-th accepted sample since reset (k = 0, 1, ...), `y_out` equals Q(g, y(k−M)) + Σ_{i=0}^{M−1} Q(c_i, x(k−i)), kept to its W low bits. In this sum:
  - Q(p, q) is the full signed product p·q shifted right arithmetically by FRAC bits and kept to W bits.
  - c_0 = B and c_i = Q(A, c_{i−1}).
  - g is 1.0 (1 << FRAC) multiplied M times by A through Q.
  - Samples and outputs with negative index count as zero.
- R4: In cycles with `x_vld` low, the value on `x_in` has no effect and `y_out` keeps its last value. A stream with idle gaps produces the same outputs as the same samples sent back to back.
- R5: A reset in the middle of a stream clears all input and output history. The next sample is processed as sample 0.
- R6: Rounding floors toward minus infinity on every product. With the default coefficients (A = 12288, B = 4096, FRAC = 14), a single input of −1 followed by zeros gives an output of −1 on every sample.
- R7: The same rule as R3 holds for a look-ahead depth of M = 3. With the default coefficients, an impulse of 16384 gives 4096 and then 3072 as the first two outputs for any M ≥ 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_in | input | W | Signed input sample, FRAC fraction bits |
| x_vld | input | 1 | Input sample valid |
| y_out | output | W | Signed filtered output, held between samples |
| y_vld | output | 1 | One-cycle pulse marking a new output |

## Verification
The checker watches, on every cycle, the handshake between `x_vld` and `y_vld`, the holding of `y_out` across idle cycles, and the cleared state while reset is held. The numeric content of the output cannot be expressed as a simple property. Only the bench scenarios can show it: bit-exact agreement with the look-ahead recursion, floor rounding on negative values, history clearing by a mid-stream reset, and the M = 3 variant.

// File: rtl/la_iir1_pkg.sv
package la_iir1_pkg;

    // Keep the low w bits of v and sign-extend them.
    function automatic longint fx_wrap(longint v, int w);
        longint span;
        longint r;
        span = longint'(1) << w;
        r    = v & (span - 1);
        if (r >= (span >> 1)) r = r - span;
        return r;
    endfunction

    // Fixed-point product: floor shift by frac, wrap to w bits.
    function automatic longint fx_mul(longint a, longint b, int frac, int w);
        return fx_wrap((a * b) >>> frac, w);
    endfunction

    // Gain a raised to power n, starting from 1.0, through fx_mul.
    function automatic longint fx_pow(longint a, int n, int frac, int w);
        longint r;
        r = fx_wrap(longint'(1) << frac, w);
        for (int k = 0; k < n; k++) r = fx_mul(a, r, frac, w);
        return r;
    endfunction

    // Feed-forward tap i: b scaled i times by a.
    function automatic longint fx_tap(longint a, longint b, int i, int frac, int w);
        longint r;
        r = fx_wrap(b, w);
        for (int k = 0; k < i; k++) r = fx_mul(a, r, frac, w);
        return r;
    endfunction

endpackage

// File: rtl/la_iir1_ffwd.sv
module la_iir1_ffwd #(
    parameter int W    = 16,
    parameter int FRAC = 14,
    parameter int M    = 2,
    parameter int A    = 12288,
    parameter int B    = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic signed [W-1:0] x_cur,
    output logic signed [W-1:0] ff_sum
);
    localparam int NDLY = M - 1;

    typedef struct packed {
        logic [NDLY-1:0][W-1:0] xd;
    } ff_state_t;

    ff_state_t s_d, s_q;

    logic signed [W-1:0] tap  [M];
    logic signed [W-1:0] term [M];

    assign tap[0] = x_cur;
    for (genvar i = 1; i < M; i++) begin : g_tap
        assign tap[i] = s_q.xd[i-1];
    end

    for (genvar i = 0; i < M; i++) begin : g_term
        localparam logic signed [W-1:0] CI =
            W'(la_iir1_pkg::fx_tap(longint'(A), longint'(B), i, FRAC, W));
        logic signed [2*W-1:0] prod;
        assign prod    = (2*W)'(tap[i]) * (2*W)'(CI);
        assign term[i] = W'(prod >>> FRAC);
    end

    always_comb begin
        logic signed [W-1:0] acc;
        acc = '0;
        for (int k = 0; k < M; k++) acc = acc + term[k];
        ff_sum = acc;
    end

    always_comb begin
        s_d = s_q;
        if (adv) begin
            s_d.xd[0] = x_cur;
            for (int k = 1; k < NDLY; k++) s_d.xd[k] = s_q.xd[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/la_iir1_fbk.sv
module la_iir1_fbk #(
    parameter int W    = 16,
    parameter int FRAC = 14,
    parameter int M    = 2,
    parameter int A    = 12288
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic signed [W-1:0] y_now,
    output logic signed [W-1:0] fb_term
);
    localparam int NCH = M - 2;
    localparam logic signed [W-1:0] AM =
        W'(la_iir1_pkg::fx_pow(longint'(A), M, FRAC, W));

    logic signed [W-1:0] tail;

    if (NCH == 0) begin : g_nochain
        assign tail = y_now;
    end else begin : g_chain
        typedef struct packed {
            logic [NCH-1:0][W-1:0] yd;
        } ch_state_t;

        ch_state_t c_d, c_q;

        always_comb begin
            c_d = c_q;
            if (adv) begin
                c_d.yd[0] = y_now;
                for (int k = 1; k < NCH; k++) c_d.yd[k] = c_q.yd[k-1];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) c_q <= '0;
            else        c_q <= c_d;
        end

        assign tail = c_q.yd[NCH-1];
    end

    typedef struct packed {
        logic signed [W-1:0] prod;
    } pr_state_t;

    pr_state_t p_d, p_q;
    logic signed [2*W-1:0] full;

    assign full = (2*W)'(tail) * (2*W)'(AM);

    always_comb begin
        p_d = p_q;
        if (adv) p_d.prod = W'(full >>> FRAC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign fb_term = p_q.prod;

endmodule

// File: rtl/la_iir1.sv
module la_iir1 #(
    parameter int W    = 16,
    parameter int FRAC = 14,
    parameter int M    = 2,
    parameter int A    = 12288,
    parameter int B    = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] x_in,
    input  logic                x_vld,
    output logic signed [W-1:0] y_out,
    output logic                y_vld
);
    typedef struct packed {
        logic signed [W-1:0] y;
        logic                vld;
    } out_state_t;

    out_state_t r_d, r_q;

    logic signed [W-1:0] ff_sum;
    logic signed [W-1:0] fb_term;

    la_iir1_ffwd #(.W(W), .FRAC(FRAC), .M(M), .A(A), .B(B)) u_ffwd (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (x_vld),
        .x_cur  (x_in),
        .ff_sum (ff_sum)
    );

    la_iir1_fbk #(.W(W), .FRAC(FRAC), .M(M), .A(A)) u_fbk (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (x_vld),
        .y_now   (r_q.y),
        .fb_term (fb_term)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = x_vld;
        if (x_vld) r_d.y = ff_sum + fb_term;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign y_out = r_q.y;
    assign y_vld = r_q.vld;

endmodule

// File: rtl/la_iir1_chk.sv
module la_iir1_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         x_vld,
    input logic         y_vld,
    input logic [W-1:0] y_out
);
    // R1
    r1_reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!y_vld && y_out == '0));

    // R2
    r2_vld_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x_vld |=> y_vld);

    // R2
    r2_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !x_vld |=> !y_vld);

    // R4
    r4_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !x_vld |=> $stable(y_out));

endmodule

bind la_iir1 la_iir1_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .x_vld (x_vld),
    .y_vld (y_vld),
    .y_out (y_out)
);

// File: tb/tb_la_iir1.sv
`timescale 1ns/1ps
module tb_la_iir1;
    localparam int W    = 16;
    localparam int FRAC = 14;
    localparam int A    = 12288;
    localparam int B    = 4096;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic signed [W-1:0] x_in = '0;
    logic                x_vld = 1'b0;
    logic signed [W-1:0] y2, y3;
    logic                v2, v3;

    int n_chk = 0;
    int n_bad = 0;
    int ns = 0;
    int xh  [512];
    int yh2 [512];
    int yh3 [512];

    always #4 clk = ~clk;

    la_iir1 #(.W(W), .FRAC(FRAC), .M(2), .A(A), .B(B)) dut (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .x_vld(x_vld), .y_out(y2), .y_vld(v2));

    la_iir1 #(.W(W), .FRAC(FRAC), .M(3), .A(A), .B(B)) dut_m3 (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .x_vld(x_vld), .y_out(y3), .y_vld(v3));

    function automatic int q(int a, int b);
        longint p;
        p = (longint'(a) * longint'(b)) >>> FRAC;
        return int'(shortint'(p));
    endfunction

    function automatic int model(int m, int k);
        int c, pw, acc, yp;
        pw = 1 << FRAC;
        for (int i = 0; i < m; i++) pw = q(A, pw);
        acc = 0;
        if (k - m >= 0) begin
            yp  = (m == 2) ? yh2[k-m] : yh3[k-m];
            acc = q(pw, yp);
        end
        c = B;
        for (int i = 0; i < m; i++) begin
            if (k - i >= 0) acc = acc + q(c, xh[k-i]);
            c = q(A, c);
        end
        return int'(shortint'(acc));
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Apply one sample, check it, then idle for gap cycles (called at a negedge).
    task automatic push(int x, int gap, string tag);
        int e2, e3;
        x_in  = W'(x);
        x_vld = 1'b1;
        xh[ns] = x;
        e2 = model(2, ns); yh2[ns] = e2;
        e3 = model(3, ns); yh3[ns] = e3;
        ns++;
        @(negedge clk);
        x_vld = 1'b0;
        x_in  = 16'sh5A5A;
        check("R2 valid pulse", int'(v2), 1);
        check(tag, int'(y2), e2);
        check("R7 depth-3 output", int'(y3), e3);
        for (int g = 0; g < gap; g++) begin
            x_in = W'(g * 7919 - 12000);
            @(negedge clk);
            check("R2 idle valid", int'(v2), 0);
            check("R4 idle hold", int'(y2), e2);
            check("R4 idle hold M3", int'(y3), e3);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        x_vld = 1'b0;
        @(negedge clk);
        check("R1 reset valid", int'(v2), 0);
        check("R1 reset output", int'(y2), 0);
        check("R1 reset valid M3", int'(v3), 0);
        check("R1 reset output M3", int'(y3), 0);
        rst_n = 1'b1;
        ns = 0;
        @(negedge clk);
        check("R1 after release", int'(y2), 0);
        check("R1 after release valid", int'(v2), 0);
    endtask

    task automatic t_impulse();
        push(16384, 0, "R3 impulse");
        check("R7 impulse first", yh2[0], 4096);
        check("R7 impulse first M3", int'(y3), 4096);
        push(0, 0, "R3 impulse");
        check("R7 impulse second", int'(y2), 3072);
        check("R7 impulse second M3", int'(y3), 3072);
        for (int i = 0; i < 8; i++) push(0, 0, "R3 impulse tail");
    endtask

    task automatic t_step();
        do_reset();
        for (int i = 0; i < 12; i++) push(8000, 0, "R3 step");
    endtask

    task automatic t_alternating();
        do_reset();
        for (int i = 0; i < 12; i++) push((i % 2) ? -9000 : 11000 - i * 300, 0, "R3 alternating");
    endtask

    task automatic t_gaps();
        do_reset();
        push(7000, 3, "R4 gapped");
        push(-2500, 1, "R4 gapped");
        push(12000, 2, "R4 gapped");
        push(300, 0, "R4 gapped");
        push(-15000, 4, "R4 gapped");
        push(0, 1, "R4 gapped");
    endtask

    task automatic t_floor();
        do_reset();
        push(-1, 0, "R6 floor");
        check("R6 floor first", int'(y2), -1);
        for (int i = 0; i < 5; i++) begin
            push(0, 0, "R6 floor");
            check("R6 floor tail", int'(y2), -1);
            check("R6 floor tail M3", int'(y3), -1);
        end
    endtask

    task automatic t_midreset();
        do_reset();
        for (int i = 0; i < 5; i++) push(5000, 0, "R5 pre-reset");
        do_reset();
        push(16384, 0, "R5 after reset");
        check("R5 fresh first", int'(y2), 4096);
        push(0, 0, "R5 after reset");
        check("R5 fresh second", int'(y2), 3072);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        do_reset();
        t_impulse();
        t_step();
        t_alternating();
        t_gaps();
        t_floor();
        t_midreset();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule